// File: doc/BRIEF.md
# Microcoded Accumulator Datapath

This block is the execution half of a small microprogrammed processor. It holds a 16-bit accumulator, a 16-bit data register, an 11-bit address register and an 11-bit program counter, together with a 2048-word by 16-bit main memory. A sequencer outside the block presents three 3-bit operation selectors every clock. Each selector names one register transfer from its own set of seven, and all three transfers are applied together at the next rising edge.

The block returns the branch-condition bits and the opcode bits to the sequencer. A stored instruction word carries the indirect flag in bit 15, a 4-bit opcode in bits 14..11 and an 11-bit address in bits 10..0. A preload path lets a test environment fill memory and set the program counter. The control store and the next-address logic are not part of this block.

Top module: `acc_datapath`

## Requirements
- R1: While `rst_n` is low, AC, DR, AR and PC are all zero.
- R2: Selector A (`opa_i`) applies these transfers: 0 none, 1 AC←AC+DR, 2 AC←0, 3 AC←AC+1, 4 AC←DR, 5 AR←DR[10:0], 6 AR←PC, 7 memory[AR]←DR.
- R3: Selector B (`opb_i`) applies these transfers: 0 none, 1 AC←AC−DR, 2 AC←AC|DR, 3 AC←AC&DR, 4 DR←memory[AR], 5 DR←AC, 6 DR←DR+1, 7 DR[10:0]←PC with DR[15:11] kept.
- R4: Selector C (`opc_i`) applies these transfers: 0 none, 1 AC←AC^DR, 2 AC←~AC, 3 AC shifted left one place, 4 AC shifted right one place, 5 PC←PC+1, 6 PC←AR, 7 no effect.
- R5: Every transfer reads the register values from before the edge. Selector A code 4 with selector B code 5 therefore exchanges AC and DR.
- R6: When more than one selector writes AC in the same step, C takes precedence over B, and B over A.
- R7: A memory write lands at the clock edge. A memory read in the same step (A code 7 with B code 4) returns the word as it stood before the edge.
- R8: Additions, increments and subtraction wrap modulo 2^16, or modulo 2^11 for PC. Both shifts bring a zero into the bit they vacate.
- R9: `dr_msb_o` is DR[15], `ac_msb_o` is AC[15], `ac_zero_o` is high exactly when AC is zero, and `opcode_o` is DR[14:11].
- R10: `ld_mem_i` writes `ld_data_i` to memory at `ld_addr_i` and overrides a selector write in the same step. `ld_pc_i` loads PC from `ld_pc_val_i` and overrides selector C.
- R11: A register that no selector writes in a step keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa_i | input | 3 | Selector A code |
| opb_i | input | 3 | Selector B code |
| opc_i | input | 3 | Selector C code |
| ld_mem_i | input | 1 | Preload memory write strobe |
| ld_addr_i | input | 11 | Preload memory address |
| ld_data_i | input | 16 | Preload memory data |
| ld_pc_i | input | 1 | Preload PC strobe |
| ld_pc_val_i | input | 11 | Preload PC value |
| dr_msb_o | output | 1 | DR bit 15 (indirect flag) |
| ac_msb_o | output | 1 | AC bit 15 (sign) |
| ac_zero_o | output | 1 | AC equals zero |
| opcode_o | output | 4 | DR bits 14..11 |
| ac_o | output | 16 | Accumulator |
| dr_o | output | 16 | Data register |
| ar_o | output | 11 | Address register |
| pc_o | output | 11 | Program counter |

## Verification
Two kinds of step can collide in the same cycle. In the first, AC→DR and DR→AC fire together, or selectors B and C both target AC. In the second, a memory write and a memory read hit the same address. Directed steps set up each pairing with distinct register values, and random steps then mix all three selectors freely. A behavioural model advances one step per clock using only pre-edge values and field precedence. Every register and flag is compared against it after each edge, and a later read confirms what the colliding write left in memory.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 11;
  localparam int OPC_W  = 4;

  typedef enum logic [2:0] {
    A_NONE, A_ADD, A_CLR, A_INC, A_DR2AC, A_DR2AR, A_PC2AR, A_WRITE
  } opa_e;

  typedef enum logic [2:0] {
    B_NONE, B_SUB, B_OR, B_AND, B_READ, B_AC2DR, B_INCDR, B_PC2DR
  } opb_e;

  typedef enum logic [2:0] {
    C_NONE, C_XOR, C_COM, C_SHL, C_SHR, C_INCPC, C_AR2PC, C_RSVD
  } opc_e;

  function automatic logic [DATA_W-1:0] w_add(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DATA_W-1:0] w_sub(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return a - b;
  endfunction

  function automatic logic [DATA_W-1:0] sh_left(input logic [DATA_W-1:0] a);
    return {a[DATA_W-2:0], 1'b0};
  endfunction

  function automatic logic [DATA_W-1:0] sh_right(input logic [DATA_W-1:0] a);
    return {1'b0, a[DATA_W-1:1]};
  endfunction
endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int DW = 16,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ld_we_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_data_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  assign rdata_o = mem_q[addr_i];

  always_ff @(posedge clk) begin
    if (ld_we_i) mem_q[ld_addr_i] <= ld_data_i;
    else if (we_i) mem_q[addr_i] <= wdata_i;
  end

  // R7
  mem_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !ld_we_i) |=> (mem_q[$past(addr_i)] == $past(wdata_i)));

  // R10
  mem_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we_i |=> (mem_q[$past(ld_addr_i)] == $past(ld_data_i)));
endmodule

// File: rtl/acc_xfer.sv
module acc_xfer
  import acc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 11
) (
  input  opa_e          opa,
  input  opb_e          opb,
  input  opc_e          opc,
  input  logic [DW-1:0] ac,
  input  logic [DW-1:0] dr,
  input  logic [AW-1:0] ar,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] mem_rd,
  output logic [DW-1:0] ac_nx,
  output logic [DW-1:0] dr_nx,
  output logic [AW-1:0] ar_nx,
  output logic [AW-1:0] pc_nx,
  output logic          mem_we,
  output logic          ac_by_a,
  output logic          ac_by_b,
  output logic          ac_by_c
);
  logic [DW-1:0] ac_a, ac_b, ac_c;

  always_comb begin
    ac_by_a = 1'b1;
    unique case (opa)
      A_ADD:   ac_a = w_add(ac, dr);
      A_CLR:   ac_a = '0;
      A_INC:   ac_a = w_add(ac, DW'(1));
      A_DR2AC: ac_a = dr;
      default: begin ac_a = ac; ac_by_a = 1'b0; end
    endcase
  end

  always_comb begin
    ac_by_b = 1'b1;
    unique case (opb)
      B_SUB:   ac_b = w_sub(ac, dr);
      B_OR:    ac_b = ac | dr;
      B_AND:   ac_b = ac & dr;
      default: begin ac_b = ac; ac_by_b = 1'b0; end
    endcase
  end

  always_comb begin
    ac_by_c = 1'b1;
    unique case (opc)
      C_XOR:   ac_c = ac ^ dr;
      C_COM:   ac_c = ~ac;
      C_SHL:   ac_c = sh_left(ac);
      C_SHR:   ac_c = sh_right(ac);
      default: begin ac_c = ac; ac_by_c = 1'b0; end
    endcase
  end

  // precedence: C over B over A
  always_comb begin
    if (ac_by_c)      ac_nx = ac_c;
    else if (ac_by_b) ac_nx = ac_b;
    else              ac_nx = ac_a;
  end

  always_comb begin
    unique case (opb)
      B_READ:  dr_nx = mem_rd;
      B_AC2DR: dr_nx = ac;
      B_INCDR: dr_nx = w_add(dr, DW'(1));
      B_PC2DR: dr_nx = {dr[DW-1:AW], pc};
      default: dr_nx = dr;
    endcase
  end

  always_comb begin
    unique case (opa)
      A_DR2AR: ar_nx = dr[AW-1:0];
      A_PC2AR: ar_nx = pc;
      default: ar_nx = ar;
    endcase
  end

  always_comb begin
    unique case (opc)
      C_INCPC: pc_nx = pc + AW'(1);
      C_AR2PC: pc_nx = ar;
      default: pc_nx = pc;
    endcase
  end

  assign mem_we = (opa == A_WRITE);
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DW = acc_pkg::DATA_W,
  parameter int AW = acc_pkg::ADDR_W,
  parameter int OW = acc_pkg::OPC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    opa_i,
  input  logic [2:0]    opb_i,
  input  logic [2:0]    opc_i,
  input  logic          ld_mem_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_data_i,
  input  logic          ld_pc_i,
  input  logic [AW-1:0] ld_pc_val_i,
  output logic          dr_msb_o,
  output logic          ac_msb_o,
  output logic          ac_zero_o,
  output logic [OW-1:0] opcode_o,
  output logic [DW-1:0] ac_o,
  output logic [DW-1:0] dr_o,
  output logic [AW-1:0] ar_o,
  output logic [AW-1:0] pc_o
);
  localparam int OP_LSB = AW;
  localparam int OP_MSB = AW + OW - 1;

  opa_e opa;
  opb_e opb;
  opc_e opc;
  assign opa = opa_e'(opa_i);
  assign opb = opb_e'(opb_i);
  assign opc = opc_e'(opc_i);

  logic [DW-1:0] ac_q, dr_q, ac_nx, dr_nx, mem_rd;
  logic [AW-1:0] ar_q, pc_q, ar_nx, pc_nx;
  logic          mem_we, ac_by_a, ac_by_b, ac_by_c;

  acc_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we_i(mem_we), .addr_i(ar_q), .wdata_i(dr_q),
    .ld_we_i(ld_mem_i), .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i),
    .rdata_o(mem_rd)
  );

  acc_xfer #(.DW(DW), .AW(AW)) u_xfer (
    .opa(opa), .opb(opb), .opc(opc),
    .ac(ac_q), .dr(dr_q), .ar(ar_q), .pc(pc_q), .mem_rd(mem_rd),
    .ac_nx(ac_nx), .dr_nx(dr_nx), .ar_nx(ar_nx), .pc_nx(pc_nx),
    .mem_we(mem_we), .ac_by_a(ac_by_a), .ac_by_b(ac_by_b), .ac_by_c(ac_by_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q <= '0;
      dr_q <= '0;
      ar_q <= '0;
      pc_q <= '0;
    end else begin
      ac_q <= ac_nx;
      dr_q <= dr_nx;
      ar_q <= ar_nx;
      pc_q <= ld_pc_i ? ld_pc_val_i : pc_nx;
    end
  end

  assign ac_o      = ac_q;
  assign dr_o      = dr_q;
  assign ar_o      = ar_q;
  assign pc_o      = pc_q;
  assign dr_msb_o  = dr_q[DW-1];
  assign ac_msb_o  = ac_q[DW-1];
  assign ac_zero_o = (ac_q == '0);
  assign opcode_o  = dr_q[OP_MSB:OP_LSB];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (ac_o == '0 && dr_o == '0 && ar_o == '0 && pc_o == '0));

  // R5
  swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opa == A_DR2AC && opb == B_AC2DR && !ac_by_c) |=> (ac_q == $past(dr_q) && dr_q == $past(ac_q)));

  // R6
  c_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == C_COM) |=> (ac_q == ~$past(ac_q)));

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == C_INCPC && !ld_pc_i) |=> (pc_q == $past(pc_q) + AW'(1)));

  // R10
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pc_i |=> (pc_q == $past(ld_pc_val_i)));

  // R11
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opa != A_DR2AR && opa != A_PC2AR) |=> $stable(ar_q));

  // R11
  ac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ac_by_a && !ac_by_b && !ac_by_c) |=> $stable(ac_q));

  // R11
  dr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opb_i[2] == 1'b0) |=> $stable(dr_q));
endmodule

// File: tb/tb_acc_datapath.sv
`timescale 1ns/1ps
module tb_acc_datapath;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] opa_i = 3'd0, opb_i = 3'd0, opc_i = 3'd0;
  logic ld_mem_i = 1'b0, ld_pc_i = 1'b0;
  logic [10:0] ld_addr_i = '0, ld_pc_val_i = '0;
  logic [15:0] ld_data_i = '0;
  logic dr_msb_o, ac_msb_o, ac_zero_o;
  logic [3:0] opcode_o;
  logic [15:0] ac_o, dr_o;
  logic [10:0] ar_o, pc_o;

  always #2.5 clk = ~clk;

  acc_datapath dut (
    .clk(clk), .rst_n(rst_n), .opa_i(opa_i), .opb_i(opb_i), .opc_i(opc_i),
    .ld_mem_i(ld_mem_i), .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i),
    .ld_pc_i(ld_pc_i), .ld_pc_val_i(ld_pc_val_i),
    .dr_msb_o(dr_msb_o), .ac_msb_o(ac_msb_o), .ac_zero_o(ac_zero_o),
    .opcode_o(opcode_o), .ac_o(ac_o), .dr_o(dr_o), .ar_o(ar_o), .pc_o(pc_o)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  int m_ac, m_dr, m_ar, m_pc;
  int m_mem [2048];
  logic [31:0] seed = 32'h1f2e3d4c;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "AC", int'(ac_o), m_ac);
    chk(tag, "DR", int'(dr_o), m_dr);
    chk(tag, "AR", int'(ar_o), m_ar);
    chk(tag, "PC", int'(pc_o), m_pc);
    chk({tag, "/R9"}, "flags", int'({dr_msb_o, ac_msb_o, ac_zero_o, opcode_o}),
        ((m_dr >> 15) & 1) * 64 + ((m_ac >> 15) & 1) * 32 + (m_ac == 0 ? 16 : 0) + ((m_dr >> 11) & 15));
  endtask

  // one clock: stimulus at falling edge, model from pre-edge state, compare after edge
  task automatic step(input int a, input int b, input int c, input bit lpc, input int lpcv, input string tag);
    int nac, ndr, nar, npc, wr_addr, wr_val;
    bit wr;
    @(negedge clk);
    opa_i = 3'(a); opb_i = 3'(b); opc_i = 3'(c);
    ld_pc_i = lpc; ld_pc_val_i = 11'(lpcv);
    nac = m_ac; ndr = m_dr; nar = m_ar; npc = m_pc; wr = 0; wr_addr = m_ar; wr_val = m_dr;
    // selector A
    if (a == 1) nac = (m_ac + m_dr) & 16'hFFFF;
    if (a == 2) nac = 0;
    if (a == 3) nac = (m_ac + 1) & 16'hFFFF;
    if (a == 4) nac = m_dr;
    if (a == 5) nar = m_dr & 11'h7FF;
    if (a == 6) nar = m_pc;
    if (a == 7) wr = 1;
    // selector B replaces any AC result from A
    if (b == 1) nac = (m_ac - m_dr) & 16'hFFFF;
    if (b == 2) nac = m_ac | m_dr;
    if (b == 3) nac = m_ac & m_dr;
    if (b == 4) ndr = m_mem[m_ar];
    if (b == 5) ndr = m_ac;
    if (b == 6) ndr = (m_dr + 1) & 16'hFFFF;
    if (b == 7) ndr = (m_dr & 16'hF800) | m_pc;
    // selector C replaces any AC result from A or B
    if (c == 1) nac = m_ac ^ m_dr;
    if (c == 2) nac = (~m_ac) & 16'hFFFF;
    if (c == 3) nac = (m_ac * 2) & 16'hFFFF;
    if (c == 4) nac = m_ac / 2;
    if (c == 5) npc = (m_pc + 1) % 2048;
    if (c == 6) npc = m_ar;
    if (lpc) npc = lpcv;
    @(posedge clk);
    #1;
    m_ac = nac; m_dr = ndr; m_ar = nar; m_pc = npc;
    if (wr) m_mem[wr_addr] = wr_val;
    compare(tag);
  endtask

  task automatic preload(input int addr, input int data);
    @(negedge clk);
    opa_i = 3'd0; opb_i = 3'd0; opc_i = 3'd0; ld_pc_i = 1'b0;
    ld_mem_i = 1'b1; ld_addr_i = 11'(addr); ld_data_i = 16'(data);
    @(posedge clk);
    #1;
    m_mem[addr] = data & 16'hFFFF;
    @(negedge clk);
    ld_mem_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_ac = 0; m_dr = 0; m_ar = 0; m_pc = 0;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    for (int i = 0; i < 2048; i++) preload(i, (i * 40503 + 7) & 16'hFFFF);
    rst_n = 1'b1;
    preload(5, 16'hA803);      // indirect=1, opcode=5, address=3
    preload(3, 16'h8001);
    preload(9, 16'h0000);
    step(0, 0, 0, 1, 5, "R10 pc load");
    step(6, 0, 0, 0, 0, "R2 PC to AR");
    step(0, 4, 0, 0, 0, "R3 read / R9 opcode");
    step(5, 0, 0, 0, 0, "R2 DR to AR");
    step(0, 4, 0, 0, 0, "R3 read");
    step(4, 0, 0, 0, 0, "R2 DR to AC");
    step(0, 7, 0, 0, 0, "R3 PC into DR");
    step(3, 0, 0, 0, 0, "R2 inc AC");
    step(1, 0, 0, 0, 0, "R2 add");
    step(0, 1, 0, 0, 0, "R3 sub");
    step(0, 2, 0, 0, 0, "R3 or");
    step(0, 3, 0, 0, 0, "R3 and");
    step(0, 6, 0, 0, 0, "R3 inc DR");
    step(0, 0, 1, 0, 0, "R4 xor");
    step(0, 0, 3, 0, 0, "R4/R8 shl");
    step(0, 0, 4, 0, 0, "R4/R8 shr");
    step(0, 0, 2, 0, 0, "R4 com");
    step(0, 0, 7, 0, 0, "R4 reserved no-op");
    step(0, 0, 5, 0, 0, "R4 inc PC");
    step(0, 0, 6, 0, 0, "R4 AR to PC");
    step(4, 5, 0, 0, 0, "R5 swap");
    step(3, 2, 3, 0, 0, "R6 C over B over A");
    step(1, 1, 0, 0, 0, "R6 B over A");
    step(2, 0, 0, 0, 0, "R2/R9 clear zero flag");
    step(0, 1, 0, 0, 0, "R8 sub wraps");
    step(3, 0, 0, 0, 0, "R8 inc wraps");
    step(0, 0, 0, 1, 2047, "R10 pc to top");
    step(0, 0, 5, 0, 0, "R8 pc wraps");
    step(0, 0, 5, 1, 100, "R10 load beats inc");
    step(6, 5, 0, 0, 0, "R7 setup");
    step(7, 4, 0, 0, 0, "R7 write with read old");
    step(0, 4, 0, 0, 0, "R7 read back written");
    step(0, 0, 0, 0, 0, "R11 idle");
    for (int k = 0; k < 800; k++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      step(int'(seed[31:29]), int'(seed[28:26]), int'(seed[25:23]),
           seed[22:18] == 5'd0, int'(seed[10:0]), "R5/R6/R11 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule